// File: doc/BRIEF.md
# Serial Tuner Register Loader

This block is the two-wire (I2C) write port of a tuner frequency synthesizer. It oversamples the SCL and SDA lines with the system clock and detects START and STOP conditions. It compares the first byte of a transfer with the device address, and it asks for an acknowledge by raising a pull-down request on SDA. Every data byte that follows is steered into one of four slots: the two halves of the divider word, the control byte and the band-switch byte.

The most significant bit of the first data byte sets the order of the slots for the rest of the transfer. If it is 0, the divider comes first. If it is 1, the control byte comes first. After each byte the slot pointer advances by itself, so one addressed transfer can load every register, or only the leading part of the sequence. A register changes only when the last byte of its group has arrived. A divider half that arrives without its partner therefore never reaches the output. A mode input hands the pins to a different bus front end; while it is high, this block stays deaf to all traffic.

Top module: `tuner_i2c_loader`

## Requirements
- R1: While `bus_sel` is high, `sda_pull` stays low and no output register changes, whatever traffic appears on SCL and SDA.
- R2: The address byte is acknowledged only when its upper seven bits equal binary 11000 followed by `addr_sel[1]` and `addr_sel[0]`, and its last bit (R/W) is 0. For any other address, and for a read, the block gives no acknowledge and changes no register until the next START.
- R3: An acknowledge holds `sda_pull` high from the SCL falling edge after the 8th bit until the falling edge of the 9th clock. This applies to the matching address byte and to every data byte that follows it.
- R4: When bit 7 of the first data byte is 0, the slots follow the order divider-high, divider-low, control, band-switch.
- R5: When bit 7 of the first data byte is 1, the slots follow the order control, band-switch, divider-high, divider-low.
- R6: `freq_word` equals {divider-high[6:0], divider-low[7:0]}. It is loaded at the 8th SCL rising edge of the divider-low byte and at no other time. A divider-high byte whose partner never arrives is not committed.
- R7: `ctrl_word` and `band_word` each load the whole received byte at the 8th SCL rising edge of their own slot. At most one register loads per byte.
- R8: Data bytes after the fourth are acknowledged but change no register.
- R9: A repeated START or a STOP returns the slot pointer to the first slot. After a repeated START, the first data byte again selects the order.
- R10: After reset, `freq_word`, `ctrl_word`, `band_word` and `sda_pull` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | High: this port is inactive; low: the two-wire port listens |
| addr_sel | input | 2 | Programmable low address bits (MA1, MA0) |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line |
| sda_pull | output | 1 | Request to pull SDA low (acknowledge) |
| freq_word | output | 15 | Committed divider word |
| ctrl_word | output | 8 | Committed control byte |
| band_word | output | 8 | Committed band-switch byte |

## Verification
On every cycle the assertions check several rules. The acknowledge request appears only inside an acknowledge phase of an addressed write. It stays off while the port is deselected. Each output register moves only on the cycle after its own commit strobe, and no two registers commit on the same byte. The slot pointer is cleared after START or STOP and never passes its saturation value. The bench scenarios alone can show the other behaviours: that the two byte orders map bytes to the right registers, that the divider is assembled from the right bit fields, that an orphaned divider-high byte is dropped, and that a repeated START restarts the sequence with a new order.

// File: rtl/tl_pkg.sv
package tl_pkg;
  localparam int BYTE_W = 8;
  localparam logic [4:0] DEV_HI = 5'b11000;

  typedef enum logic [1:0] {SLOT_DIVH = 2'd0, SLOT_DIVL = 2'd1, SLOT_CTRL = 2'd2, SLOT_BAND = 2'd3} slot_e;
  typedef enum logic [1:0] {RX_IDLE, RX_ADDR, RX_DATA, RX_SKIP} rx_state_e;

  // Slot taken by the idx-th data byte; control-first order rotates by two.
  function automatic slot_e slot_at(input logic ctrl_first, input logic [1:0] idx);
    slot_at = slot_e'({idx[1] ^ ctrl_first, idx[0]});
  endfunction

  // Write address match against the fixed high bits and the select pins.
  function automatic logic addr_hit(input logic [BYTE_W-1:0] b, input logic [1:0] sel);
    addr_hit = (b[7:1] == {DEV_HI, sel}) && !b[0];
  endfunction
endpackage

// File: rtl/tl_line_sync.sv
module tl_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_c, sda_c;
  logic scl_p, sda_p, scl_s;

  for (genvar k = 0; k < STAGES; k++) begin : g_chain
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        scl_c[k] <= 1'b1;
        sda_c[k] <= 1'b1;
      end else if (k == 0) begin
        scl_c[k] <= scl_i;
        sda_c[k] <= sda_i;
      end else begin
        scl_c[k] <= scl_c[(k == 0) ? 0 : k-1];
        sda_c[k] <= sda_c[(k == 0) ? 0 : k-1];
      end
    end
  end

  assign scl_s = scl_c[STAGES-1];
  assign sda_s = sda_c[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_rise = enable &&  scl_s && !scl_p;
  assign scl_fall = enable && !scl_s &&  scl_p;
  assign start_ev = enable && scl_s && scl_p && sda_p && !sda_s;
  assign stop_ev  = enable && scl_s && scl_p && !sda_p && sda_s;
endmodule

// File: rtl/tl_byte_rx.sv
module tl_byte_rx
  import tl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [1:0]        addr_sel,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  output logic              byte_done,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              addressed,
  output logic              in_ack,
  output logic              sda_pull
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] ACK_PH   = CNT_W'(BYTE_W);

  rx_state_e         st;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] sh;
  logic              ack_on;
  logic              counting;

  assign counting  = (st == RX_ADDR) || (st == RX_DATA);
  assign rx_byte   = {sh[BYTE_W-2:0], sda_s};
  assign byte_done = enable && !start_ev && !stop_ev && (st == RX_DATA) &&
                     scl_rise && (cnt == LAST_BIT);
  assign addressed = (st == RX_DATA);
  assign sda_pull  = ack_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= RX_IDLE; cnt <= '0; sh <= '0; in_ack <= 1'b0; ack_on <= 1'b0;
    end else if (!enable || stop_ev) begin
      st <= RX_IDLE; cnt <= '0; in_ack <= 1'b0; ack_on <= 1'b0;
    end else if (start_ev) begin
      st <= RX_ADDR; cnt <= '0; in_ack <= 1'b0; ack_on <= 1'b0;
    end else if (counting) begin
      if (scl_rise && cnt < ACK_PH) begin
        sh  <= rx_byte;
        cnt <= cnt + 1'b1;
        if (cnt == LAST_BIT && st == RX_ADDR)
          st <= addr_hit(rx_byte, addr_sel) ? RX_DATA : RX_SKIP;
      end
      if (scl_fall && cnt == ACK_PH) begin
        if (!in_ack) begin
          in_ack <= 1'b1;
          ack_on <= (st == RX_DATA);
        end else begin
          in_ack <= 1'b0;
          ack_on <= 1'b0;
          cnt    <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/tl_reg_bank.sv
module tl_reg_bank
  import tl_pkg::*;
#(
  parameter int DIV_W  = 15,
  parameter int SLOTS  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ptr_clr,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic [DIV_W-1:0]  freq_word,
  output logic [BYTE_W-1:0] ctrl_word,
  output logic [BYTE_W-1:0] band_word,
  output logic              commit_f,
  output logic              commit_c,
  output logic              commit_b,
  output logic [2:0]        ptr
);
  localparam int HI_W = DIV_W - BYTE_W;
  localparam logic [2:0] PTR_MAX = 3'(SLOTS);

  logic            ctrl_first_q, order, live, shadow_ld;
  logic [HI_W-1:0] shadow;
  slot_e           slot;

  assign order     = (ptr == 3'd0) ? rx_byte[BYTE_W-1] : ctrl_first_q;
  assign slot      = slot_at(order, ptr[1:0]);
  assign live      = byte_done && (ptr < PTR_MAX);
  assign shadow_ld = live && (slot == SLOT_DIVH);
  assign commit_f  = live && (slot == SLOT_DIVL);
  assign commit_c  = live && (slot == SLOT_CTRL);
  assign commit_b  = live && (slot == SLOT_BAND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0; ctrl_first_q <= 1'b0; shadow <= '0;
      freq_word <= '0; ctrl_word <= '0; band_word <= '0;
    end else begin
      if (ptr_clr) ptr <= '0;
      else if (live) begin
        ptr <= ptr + 1'b1;
        if (ptr == 3'd0) ctrl_first_q <= rx_byte[BYTE_W-1];
      end
      if (shadow_ld) shadow    <= rx_byte[HI_W-1:0];
      if (commit_f)  freq_word <= {shadow, rx_byte};
      if (commit_c)  ctrl_word <= rx_byte;
      if (commit_b)  band_word <= rx_byte;
    end
  end
endmodule

// File: rtl/tuner_i2c_loader.sv
module tuner_i2c_loader
  import tl_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DIV_W       = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic [1:0]       addr_sel,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_pull,
  output logic [DIV_W-1:0] freq_word,
  output logic [7:0]       ctrl_word,
  output logic [7:0]       band_word
);
  logic enable, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic byte_done, addressed, in_ack, ptr_clr;
  logic commit_f, commit_c, commit_b;
  logic [BYTE_W-1:0] rx_byte;
  logic [2:0] ptr;

  assign enable  = !bus_sel;
  assign ptr_clr = start_ev || stop_ev || !enable;

  tl_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev));

  tl_byte_rx rx_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .addr_sel(addr_sel),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev), .byte_done(byte_done),
    .rx_byte(rx_byte), .addressed(addressed), .in_ack(in_ack),
    .sda_pull(sda_pull));

  tl_reg_bank #(.DIV_W(DIV_W), .SLOTS(4)) bank_i (
    .clk(clk), .rst_n(rst_n), .ptr_clr(ptr_clr), .byte_done(byte_done),
    .rx_byte(rx_byte), .freq_word(freq_word), .ctrl_word(ctrl_word),
    .band_word(band_word), .commit_f(commit_f), .commit_c(commit_c),
    .commit_b(commit_b), .ptr(ptr));
endmodule

// File: rtl/tl_checker.sv
module tl_checker #(
  parameter int DIV_W = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_sel,
  input logic             sda_pull,
  input logic             addressed,
  input logic             in_ack,
  input logic             ptr_clr,
  input logic [2:0]       ptr,
  input logic             commit_f,
  input logic             commit_c,
  input logic             commit_b,
  input logic [DIV_W-1:0] freq_word,
  input logic [7:0]       ctrl_word,
  input logic [7:0]       band_word
);
  assert_quiet_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel |=> !sda_pull);
  assert_ack_only_addressed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pull |-> addressed);
  assert_ack_in_ninth_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pull |-> in_ack);
  assert_freq_commit_point_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(freq_word) |-> $past(commit_f));
  assert_ctrl_commit_point_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_word) |-> $past(commit_c));
  assert_band_commit_point_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(band_word) |-> $past(commit_b));
  assert_single_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({commit_f, commit_c, commit_b}));
  assert_ptr_saturates_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= 3'd4);
  assert_ptr_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_clr |=> (ptr == 3'd0));
endmodule

bind tuner_i2c_loader tl_checker #(.DIV_W(DIV_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .sda_pull(sda_pull),
  .addressed(addressed), .in_ack(in_ack), .ptr_clr(ptr_clr), .ptr(ptr),
  .commit_f(commit_f), .commit_c(commit_c), .commit_b(commit_b),
  .freq_word(freq_word), .ctrl_word(ctrl_word), .band_word(band_word));

// File: tb/tuner_i2c_loader_tb_top.sv
`timescale 1ns/1ps
module tuner_i2c_loader_tb_top;
  localparam int PH = 10;

  logic clk = 1'b0, rst_n = 1'b0, bus_sel = 1'b0, scl = 1'b1, sda = 1'b1;
  logic [1:0] asel = 2'b00;
  logic sda_pull;
  logic [14:0] freq_word;
  logic [7:0] ctrl_word, band_word;
  int n_chk = 0, n_bad = 0, acks = 0;

  always #5 clk = ~clk;

  tuner_i2c_loader dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .addr_sel(asel),
    .scl_i(scl), .sda_i(sda), .sda_pull(sda_pull), .freq_word(freq_word),
    .ctrl_word(ctrl_word), .band_word(band_word));

  typedef struct packed {
    logic        sel;
    logic [1:0]  pins;
    logic [7:0]  addr;
    logic [2:0]  n;
    logic [39:0] data;
    logic [15:0] ef;
    logic [7:0]  ec;
    logic [7:0]  eb;
    logic [2:0]  ea;
    logic [31:0] tag;
  } vec_t;

  // Expected register values accumulate across the table rows.
  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 2'b00, 8'hC0, 3'd4, 40'h12348E0500, 16'h1234, 8'h8E, 8'h05, 3'd5, "R4  "},
    '{1'b0, 2'b10, 8'hC4, 3'd4, 40'hCA0F3F7B00, 16'h3F7B, 8'hCA, 8'h0F, 3'd5, "R5  "},
    '{1'b0, 2'b10, 8'hC4, 3'd2, 40'h0566000000, 16'h0566, 8'hCA, 8'h0F, 3'd3, "R6  "},
    '{1'b0, 2'b10, 8'hC4, 3'd1, 40'h1100000000, 16'h0566, 8'hCA, 8'h0F, 3'd2, "R6  "},
    '{1'b0, 2'b10, 8'hC6, 3'd2, 40'h2233000000, 16'h0566, 8'hCA, 8'h0F, 3'd0, "R2  "},
    '{1'b0, 2'b10, 8'hC5, 3'd1, 40'h0100000000, 16'h0566, 8'hCA, 8'h0F, 3'd0, "R2  "},
    '{1'b1, 2'b10, 8'hC4, 3'd2, 40'h4455000000, 16'h0566, 8'hCA, 8'h0F, 3'd0, "R1  "},
    '{1'b0, 2'b01, 8'hC2, 3'd5, 40'h80AA123499, 16'h1234, 8'h80, 8'hAA, 3'd6, "R8  "},
    '{1'b0, 2'b11, 8'hC6, 3'd2, 40'h9F3C000000, 16'h1234, 8'h9F, 8'h3C, 3'd3, "R7  "},
    '{1'b0, 2'b00, 8'hC0, 3'd3, 40'h7FFF010000, 16'h7FFF, 8'h01, 8'h3C, 3'd4, "R4  "}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(); repeat (PH) @(negedge clk); endtask

  task automatic bus_start();
    sda = 1'b1; wt(); scl = 1'b1; wt(); sda = 1'b0; wt(); scl = 1'b0; wt();
  endtask

  task automatic bus_stop();
    sda = 1'b0; wt(); scl = 1'b1; wt(); sda = 1'b1; wt(); wt();
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int k = 7; k >= 0; k--) begin
      sda = b[k]; wt(); scl = 1'b1; wt(); scl = 1'b0; wt();
    end
    sda = 1'b1; wt(); scl = 1'b1; repeat (PH/2) @(negedge clk);
    if (sda_pull) acks++;
    repeat (PH/2) @(negedge clk); scl = 1'b0; wt();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R10: reset state
    chk(freq_word == 15'd0, "R10 freq", freq_word, 0);
    chk(ctrl_word == 8'd0, "R10 ctrl", ctrl_word, 0);
    chk(band_word == 8'd0, "R10 band", band_word, 0);
    chk(sda_pull == 1'b0, "R10 sda_pull", sda_pull, 0);
    rst_n = 1'b1;
    wt();

    for (int i = 0; i < NV; i++) begin
      bus_sel = VEC[i].sel; asel = VEC[i].pins; acks = 0; wt();
      bus_start();
      send_byte(VEC[i].addr);
      for (int j = 0; j < int'(VEC[i].n); j++) send_byte(VEC[i].data[39-8*j -: 8]);
      bus_stop(); wt();
      chk(acks == int'(VEC[i].ea), $sformatf("R3 acks row %0d %s", i, VEC[i].tag), acks, VEC[i].ea);
      chk(freq_word == VEC[i].ef[14:0], $sformatf("R6 freq row %0d %s", i, VEC[i].tag), freq_word, VEC[i].ef);
      chk(ctrl_word == VEC[i].ec, $sformatf("R7 ctrl row %0d %s", i, VEC[i].tag), ctrl_word, VEC[i].ec);
      chk(band_word == VEC[i].eb, $sformatf("R7 band row %0d %s", i, VEC[i].tag), band_word, VEC[i].eb);
      bus_sel = 1'b0; wt();
    end

    // R9: orphan divider-high, repeated START, then control-first byte
    acks = 0;
    bus_start(); send_byte(8'hC0); send_byte(8'h15);
    sda = 1'b1; wt(); scl = 1'b1; wt(); sda = 1'b0; wt(); scl = 1'b0; wt();
    send_byte(8'hC0); send_byte(8'h81); bus_stop(); wt();
    chk(freq_word == 15'h7FFF, "R9 freq kept", freq_word, 16'h7FFF);
    chk(ctrl_word == 8'h81, "R9 ctrl reorder", ctrl_word, 8'h81);
    chk(band_word == 8'h3C, "R9 band kept", band_word, 8'h3C);
    chk(acks == 4, "R9 acks", acks, 4);

    // R1: STOP then a transfer while deselected leaves everything unchanged
    bus_sel = 1'b1; acks = 0; wt();
    bus_start(); send_byte(8'hC0); send_byte(8'h80); send_byte(8'h77); bus_stop(); wt();
    chk(acks == 0, "R1 no ack", acks, 0);
    chk(ctrl_word == 8'h81, "R1 ctrl", ctrl_word, 8'h81);
    chk(band_word == 8'h3C, "R1 band", band_word, 8'h3C);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule